// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block collects interrupt requests from eight sources of an 8-bit microcontroller and turns them into one request line and one vector address for the CPU. The sources are four active-low external pins, two simple timers (0 and 1), a third timer with two request flags, and a serial port with separate receive and transmit flags. Each external pin can be set to edge or level detection on its own. Every source has its own enable, and one global enable gates all of them. A two-bit priority per source, split across a high bit and a low bit, gives four levels.

The CPU answers a request with a one-cycle acknowledge pulse, and it ends a handler with a one-cycle return pulse. The block keeps one in-service bit per level, so handlers can nest: a request is raised only when its level is strictly above every level that is already being served. On acknowledge, the flag behind the request is cleared or kept according to the kind of source. Software can write any of the ten request flags through a small write port. A software write acts just like a hardware event, so setting a flag by software makes an interrupt pending.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every request flag is 0 (with the external pins held high), every in-service bit is 0, and `irq_req` is 0.
- R2: A source takes part in arbitration only when its bit in `src_en` is 1 and `glob_en` is 1. When `glob_en` is 0, `irq_req` is 0 in the same cycle.
- R3: The level of source k is `{pri_hi[k], pri_lo[k]}`, where 3 is the highest level. Among the pending sources, the one at the highest level wins.
- R4: Sources are numbered k = 0..7 in this order: INT0, T0, INT1, T1, serial, T2, INT2, INT3. Within one level the lowest k wins. `irq_vec` is 8*k + 3, which gives 03H to 3BH.
- R5: `irq_req` is 1 only when the winning level is strictly greater than the highest in-service level, or when no level is in service.
- R6: An `ack` while `irq_req` is 1 sets the in-service bit of the winning level. An `ack` while `irq_req` is 0 has no effect. A `reti` clears the highest set in-service bit.
- R7: With `ext_edge[i]`=1, the pin's flag sets at the clock edge where the pin is sampled low after having been sampled high at the previous edge. Acknowledging that source clears the flag.
- R8: With `ext_edge[i]`=0, the pin's flag takes the inverted pin value at every edge. Acknowledging the source does not clear it.
- R9: The timer 0 and timer 1 flags (flag indices 1 and 3) set on their event pulse and clear when their source is acknowledged.
- R10: The serial request is RI (index 4) OR TI (index 5). The timer 2 request is TF2 (index 6) OR EXF2 (index 7). None of these four flags is cleared by an acknowledge.
- R11: When `sw_we`=1, flag `sw_idx` takes `sw_val`. The flag indices are 0 IE0, 1 TF0, 2 IE1, 3 TF1, 4 RI, 5 TI, 6 TF2, 7 EXF2, 8 IE2, 9 IE3. A software write overrides any hardware event or acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 4 | External request pins, active low (INT0..INT3) |
| ext_edge | input | 4 | Per-pin detect type: 1 edge, 0 level |
| tmr_ovf | input | 2 | Overflow event pulses of timers 0 and 1 |
| ser_rx_evt | input | 1 | Serial receive-done pulse |
| ser_tx_evt | input | 1 | Serial transmit-done pulse |
| t2_ovf_evt | input | 1 | Timer 2 overflow pulse |
| t2_ext_evt | input | 1 | Timer 2 external event pulse |
| src_en | input | 8 | Per-source enables, indexed by source number k |
| glob_en | input | 1 | Global enable |
| pri_hi | input | 8 | High priority bit per source |
| pri_lo | input | 8 | Low priority bit per source |
| sw_we | input | 1 | Software flag write strobe |
| sw_idx | input | 4 | Flag index written |
| sw_val | input | 1 | Value written |
| ack | input | 1 | CPU vector-acknowledge pulse |
| reti | input | 1 | CPU return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the winning source |
| in_svc | output | 4 | In-service bit per level |
| flags | output | 10 | Current request flags, by flag index |

## Verification
The bench first steps through a table of enable and priority patterns with every flag set. This catches a design that ranks the levels in the wrong order, polls ties in the wrong order, or ignores one of the enables. A design that gets any of these wrong shows the wrong vector or a stray request. Directed sequences then nest a level-1 handler over a level-0 handler, return twice, and check that a same-level request stays held off while the lower handler runs. A design that compares levels with greater-or-equal, or that clears the wrong in-service bit on return, fails there. The bench also checks, for each kind of source, whether the flag survives an acknowledge, and it pits a software clear against a hardware event in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 8;
    localparam int NLVL  = 4;
    localparam int NFLAG = 10;
    localparam int NEXT  = 4;
    localparam int SRCW  = $clog2(NSRC);
    localparam int LVLW  = $clog2(NLVL);
    localparam int FLGW  = $clog2(NFLAG);
    localparam int VECW  = 8;
    localparam logic [2:0] VEC_LOW = 3'b011;

    typedef enum logic [3:0] {
        FL_IE0 = 4'd0, FL_TF0 = 4'd1, FL_IE1 = 4'd2, FL_TF1 = 4'd3,
        FL_RI  = 4'd4, FL_TI  = 4'd5, FL_TF2 = 4'd6, FL_EXF2 = 4'd7,
        FL_IE2 = 4'd8, FL_IE3 = 4'd9
    } flag_e;

    // source numbers (polling order)
    localparam logic [SRCW-1:0] S_INT0 = 3'd0;
    localparam logic [SRCW-1:0] S_T0   = 3'd1;
    localparam logic [SRCW-1:0] S_INT1 = 3'd2;
    localparam logic [SRCW-1:0] S_T1   = 3'd3;
    localparam logic [SRCW-1:0] S_SER  = 3'd4;
    localparam logic [SRCW-1:0] S_T2   = 3'd5;
    localparam logic [SRCW-1:0] S_INT2 = 3'd6;
    localparam logic [SRCW-1:0] S_INT3 = 3'd7;

    function automatic logic [FLGW-1:0] ext_flag(input int i);
        case (i)
            0:       return FL_IE0;
            1:       return FL_IE1;
            2:       return FL_IE2;
            default: return FL_IE3;
        endcase
    endfunction

    function automatic logic [SRCW-1:0] ext_src(input int i);
        case (i)
            0:       return S_INT0;
            1:       return S_INT1;
            2:       return S_INT2;
            default: return S_INT3;
        endcase
    endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin_n,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [1:0]      tmr_ovf,
    input  logic            ser_rx_evt,
    input  logic            ser_tx_evt,
    input  logic            t2_ovf_evt,
    input  logic            t2_ext_evt,
    input  logic            sw_we,
    input  logic [FLGW-1:0] sw_idx,
    input  logic            sw_val,
    input  logic            ack_fire,
    input  logic [SRCW-1:0] ack_src,
    output logic [NFLAG-1:0] flags,
    output logic [NSRC-1:0]  src_req
);
    typedef struct packed {
        logic [NFLAG-1:0] flag;
        logic [NEXT-1:0]  pin_prev;
    } fl_state_t;

    fl_state_t q, d;

    always_comb begin
        d = q;
        d.pin_prev = ext_pin_n;

        // clear on vectoring: edge-mode pins and timers 0/1 only
        if (ack_fire) begin
            if (ack_src == S_T0) d.flag[FL_TF0] = 1'b0;
            if (ack_src == S_T1) d.flag[FL_TF1] = 1'b0;
            for (int i = 0; i < NEXT; i++) begin
                if (ack_src == ext_src(i) && ext_edge[i])
                    d.flag[ext_flag(i)] = 1'b0;
            end
        end

        // hardware events
        for (int i = 0; i < NEXT; i++) begin
            if (ext_edge[i]) begin
                if (q.pin_prev[i] && !ext_pin_n[i])
                    d.flag[ext_flag(i)] = 1'b1;
            end else begin
                d.flag[ext_flag(i)] = !ext_pin_n[i];
            end
        end
        if (tmr_ovf[0]) d.flag[FL_TF0]  = 1'b1;
        if (tmr_ovf[1]) d.flag[FL_TF1]  = 1'b1;
        if (ser_rx_evt) d.flag[FL_RI]   = 1'b1;
        if (ser_tx_evt) d.flag[FL_TI]   = 1'b1;
        if (t2_ovf_evt) d.flag[FL_TF2]  = 1'b1;
        if (t2_ext_evt) d.flag[FL_EXF2] = 1'b1;

        // software write wins
        if (sw_we && sw_idx < FLGW'(NFLAG))
            d.flag[sw_idx] = sw_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.flag     <= '0;
            q.pin_prev <= '1;
        end else begin
            q <= d;
        end
    end

    assign flags = q.flag;
    assign src_req[S_INT0] = q.flag[FL_IE0];
    assign src_req[S_T0]   = q.flag[FL_TF0];
    assign src_req[S_INT1] = q.flag[FL_IE1];
    assign src_req[S_T1]   = q.flag[FL_TF1];
    assign src_req[S_SER]  = q.flag[FL_RI] | q.flag[FL_TI];
    assign src_req[S_T2]   = q.flag[FL_TF2] | q.flag[FL_EXF2];
    assign src_req[S_INT2] = q.flag[FL_IE2];
    assign src_req[S_INT3] = q.flag[FL_IE3];

    // R9
    t0_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_src == S_T0 && !tmr_ovf[0] && !sw_we) |=> !q.flag[FL_TF0]);

    // R10
    ser_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_src == S_SER && q.flag[FL_RI] && !sw_we) |=> q.flag[FL_RI]);

    // R7
    int0_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge[0] && q.pin_prev[0] && !ext_pin_n[0] && !sw_we) |=> q.flag[FL_IE0]);

    // R8
    int1_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_edge[1] && !sw_we) |=> (q.flag[FL_IE1] == !$past(ext_pin_n[1])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] pri_hi,
    input  logic [NSRC-1:0] pri_lo,
    input  logic            svc_any,
    input  logic [LVLW-1:0] svc_top,
    output logic            irq_req,
    output logic [SRCW-1:0] win_src,
    output logic [LVLW-1:0] win_lvl,
    output logic [VECW-1:0] vec
);
    logic [NSRC-1:0] pend;
    logic            found;

    assign pend = src_req & src_en & {NSRC{glob_en}};

    always_comb begin
        found   = 1'b0;
        win_src = '0;
        win_lvl = '0;
        for (int l = NLVL - 1; l >= 0; l--) begin
            for (int k = 0; k < NSRC; k++) begin
                if (!found && pend[k] && {pri_hi[k], pri_lo[k]} == LVLW'(l)) begin
                    found   = 1'b1;
                    win_src = SRCW'(k);
                    win_lvl = LVLW'(l);
                end
            end
        end
    end

    assign irq_req = found && (!svc_any || win_lvl > svc_top);
    assign vec     = {{(VECW-SRCW-3){1'b0}}, win_src, VEC_LOW};
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_fire,
    input  logic [LVLW-1:0] ack_lvl,
    input  logic            reti,
    output logic [NLVL-1:0] in_svc,
    output logic            svc_any,
    output logic [LVLW-1:0] svc_top
);
    typedef struct packed {
        logic [NLVL-1:0] isv;
    } sv_state_t;

    sv_state_t q, d;

    always_comb begin
        svc_top = '0;
        for (int l = 0; l < NLVL; l++)
            if (q.isv[l]) svc_top = LVLW'(l);
    end
    assign svc_any = |q.isv;

    always_comb begin
        d = q;
        if (reti && svc_any) d.isv[svc_top] = 1'b0;
        if (ack_fire)        d.isv[ack_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_svc = q.isv;

    // R6
    ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> q.isv[$past(ack_lvl)]);

    // R6
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && svc_any && !ack_fire) |=>
            ($countones(q.isv) + 1 == $countones($past(q.isv))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_rx_evt,
    input  logic             ser_tx_evt,
    input  logic             t2_ovf_evt,
    input  logic             t2_ext_evt,
    input  logic [NSRC-1:0]  src_en,
    input  logic             glob_en,
    input  logic [NSRC-1:0]  pri_hi,
    input  logic [NSRC-1:0]  pri_lo,
    input  logic             sw_we,
    input  logic [FLGW-1:0]  sw_idx,
    input  logic             sw_val,
    input  logic             ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VECW-1:0]  irq_vec,
    output logic [NLVL-1:0]  in_svc,
    output logic [NFLAG-1:0] flags
);
    logic [NSRC-1:0] src_req;
    logic [SRCW-1:0] win_src;
    logic [LVLW-1:0] win_lvl;
    logic            svc_any;
    logic [LVLW-1:0] svc_top;
    logic            ack_fire;

    assign ack_fire = ack & irq_req;

    irq_flags u_flags (
        .clk, .rst_n, .ext_pin_n, .ext_edge, .tmr_ovf,
        .ser_rx_evt, .ser_tx_evt, .t2_ovf_evt, .t2_ext_evt,
        .sw_we, .sw_idx, .sw_val,
        .ack_fire, .ack_src(win_src),
        .flags, .src_req
    );

    irq_arbiter u_arb (
        .src_req, .src_en, .glob_en, .pri_hi, .pri_lo,
        .svc_any, .svc_top,
        .irq_req, .win_src, .win_lvl, .vec(irq_vec)
    );

    irq_svc_stack u_svc (
        .clk, .rst_n, .ack_fire, .ack_lvl(win_lvl), .reti,
        .in_svc, .svc_any, .svc_top
    );

    // R4
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == VEC_LOW));

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !in_svc[win_lvl]);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_pin_n = 4'hF;
    logic [3:0] ext_edge = 4'hF;
    logic [1:0] tmr_ovf = 2'b00;
    logic       ser_rx_evt = 1'b0, ser_tx_evt = 1'b0;
    logic       t2_ovf_evt = 1'b0, t2_ext_evt = 1'b0;
    logic [7:0] src_en = 8'hFF;
    logic       glob_en = 1'b1;
    logic [7:0] pri_hi = 8'h00, pri_lo = 8'h00;
    logic       sw_we = 1'b0;
    logic [3:0] sw_idx = 4'd0;
    logic       sw_val = 1'b0;
    logic       ack = 1'b0, reti = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic [3:0] in_svc;
    logic [9:0] flags;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl u0 (.*);

    // rows: en[33:26] glob[25] hi[24:17] lo[16:9] req[8] vec[7:0]
    localparam logic [33:0] TBL [10] = '{
        {8'hFF, 1'b1, 8'h00, 8'h00, 1'b1, 8'h03},  // R4 INT0 first
        {8'hFE, 1'b1, 8'h00, 8'h00, 1'b1, 8'h0B},  // R2 R4 INT0 masked
        {8'hFF, 1'b1, 8'h80, 8'h00, 1'b1, 8'h3B},  // R3 INT3 level 2
        {8'hFF, 1'b1, 8'h00, 8'h20, 1'b1, 8'h2B},  // R3 T2 level 1
        {8'hFF, 1'b1, 8'h14, 8'h10, 1'b1, 8'h23},  // R3 serial 3 over INT1 2
        {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00},  // R2 global off
        {8'h00, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00},  // R2 all masked
        {8'hC0, 1'b1, 8'h00, 8'h00, 1'b1, 8'h33},  // R4 INT2 over INT3
        {8'hFF, 1'b1, 8'h0A, 8'h0A, 1'b1, 8'h0B},  // R4 T0 over T1 at 3
        {8'h3C, 1'b1, 8'h08, 8'h08, 1'b1, 8'h1B}   // R3 T1 at 3
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: inputs held from the current negedge to the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_write(input int idx, input logic val);
        sw_we = 1'b1; sw_idx = 4'(idx); sw_val = val;
        step();
        sw_we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", int'(flags), 0);
        chk("R1 in_svc", int'(in_svc), 0);
        chk("R1 irq_req", int'(irq_req), 0);
        rst_n = 1'b1;
        step();
        chk("R1 flags after release", int'(flags), 0);

        // table: every flag set by software (R11), then enables/priorities
        for (int i = 0; i < 10; i++) sw_write(i, 1'b1);
        chk("R11 all flags set", int'(flags), 10'h3FF);
        for (int r = 0; r < 10; r++) begin
            src_en  = TBL[r][33:26];
            glob_en = TBL[r][25];
            pri_hi  = TBL[r][24:17];
            pri_lo  = TBL[r][16:9];
            #1;
            chk($sformatf("R2/R3 row %0d req", r), int'(irq_req), int'(TBL[r][8]));
            if (TBL[r][8])
                chk($sformatf("R3/R4 row %0d vec", r), int'(irq_vec), int'(TBL[r][7:0]));
        end
        src_en = 8'hFF; glob_en = 1'b1; pri_hi = 8'h00; pri_lo = 8'h00;
        for (int i = 0; i < 10; i++) sw_write(i, 1'b0);
        chk("R11 all flags cleared", int'(flags), 0);

        // R6 ack without request ignored
        pulse_ack();
        chk("R6 stray ack", int'(in_svc), 0);

        // R7 edge INT0
        ext_pin_n[0] = 1'b0;
        step();
        ext_pin_n[0] = 1'b1;
        chk("R7 edge sets IE0", int'(flags[0]), 1);
        chk("R4 INT0 vec", int'(irq_vec), 8'h03);
        pulse_ack();
        chk("R7 IE0 cleared on ack", int'(flags[0]), 0);
        chk("R6 level0 in service", int'(in_svc), 4'b0001);

        // R5 same level held off
        tmr_ovf = 2'b01; step(); tmr_ovf = 2'b00;
        chk("R9 TF0 set", int'(flags[1]), 1);
        chk("R5 same level no req", int'(irq_req), 0);

        // nest a level-1 T1
        pri_lo = 8'h08;
        tmr_ovf = 2'b10; step(); tmr_ovf = 2'b00;
        chk("R5 higher level req", int'(irq_req), 1);
        chk("R4 T1 vec", int'(irq_vec), 8'h1B);
        pulse_ack();
        chk("R9 TF1 cleared on ack", int'(flags[3]), 0);
        chk("R6 nested in service", int'(in_svc), 4'b0011);
        pulse_reti();
        chk("R6 reti pops level1", int'(in_svc), 4'b0001);
        chk("R5 still held", int'(irq_req), 0);
        pulse_reti();
        chk("R6 reti pops level0", int'(in_svc), 4'b0000);
        chk("R5 T0 now req", int'(irq_req), 1);
        chk("R4 T0 vec", int'(irq_vec), 8'h0B);
        pulse_ack();
        chk("R9 TF0 cleared on ack", int'(flags[1]), 0);
        pulse_reti();
        pri_lo = 8'h00;

        // R8 level INT1
        ext_edge[1] = 1'b0;
        ext_pin_n[1] = 1'b0;
        step();
        chk("R8 level sets IE1", int'(flags[2]), 1);
        chk("R4 INT1 vec", int'(irq_vec), 8'h13);
        pulse_ack();
        chk("R8 IE1 kept on ack", int'(flags[2]), 1);
        ext_pin_n[1] = 1'b1;
        step();
        chk("R8 IE1 follows pin", int'(flags[2]), 0);
        pulse_reti();
        ext_edge[1] = 1'b1;

        // R10 serial and timer 2
        ser_rx_evt = 1'b1; step(); ser_rx_evt = 1'b0;
        chk("R10 serial vec", int'(irq_vec), 8'h23);
        pulse_ack();
        chk("R10 RI kept on ack", int'(flags[4]), 1);
        pulse_reti();
        sw_write(4, 1'b0);
        chk("R11 sw clears RI", int'(flags[4]), 0);
        chk("R11 no req after clear", int'(irq_req), 0);
        t2_ext_evt = 1'b1; step(); t2_ext_evt = 1'b0;
        chk("R10 T2 vec", int'(irq_vec), 8'h2B);
        pulse_ack();
        chk("R10 EXF2 kept on ack", int'(flags[7]), 1);
        pulse_reti();
        sw_write(7, 1'b0);

        // R11 software set raises request
        sw_write(9, 1'b1);
        chk("R11 sw set IE3 req", int'(irq_req), 1);
        chk("R11 IE3 vec", int'(irq_vec), 8'h3B);
        sw_write(9, 1'b0);
        chk("R11 sw clear IE3", int'(irq_req), 0);

        // R11 software write beats hardware event
        tmr_ovf = 2'b01;
        sw_write(1, 1'b0);
        tmr_ovf = 2'b00;
        chk("R11 sw over event", int'(flags[1]), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule